// File: doc/BRIEF.md
# System Tick Down-Counter

This block is a periodic tick source for a processor subsystem. A 24-bit counter steps down by one on every clock while counting is enabled. When it reaches zero it loads a software-chosen reload value on the next clock, so one full period lasts reload+1 clock cycles. Software therefore picks the reload as the clock frequency divided by the wanted tick rate, minus one.

Three registers sit on a simple single-cycle register bus: a control/status word, the reload value and the live count. Counting and the interrupt have separate enable bits. A clock-source select bit can be read and written, and the core clock is the only source behind it. A sticky wrap flag records that the count stepped from one to zero, and a read of the control/status word clears it. The level interrupt output is the wrap flag gated by the interrupt enable. Any write to the live-count register forces the count to zero without marking a wrap. Elapsed ticks inside a period are the reload minus the live count.

Top module: `tick_timer`

## Requirements
- R1: After reset the control/status word (offset 0), the reload (offset 1) and the live count (offset 2) all read 0, and `irq` is low.
- R2: The reload register keeps only the low 24 bits of a write, and bits 31..24 of a read are zero.
- R3: With counting enabled and a nonzero reload N, the wrap flag is set once every N+1 clock cycles. A count of zero loads N on the next clock instead of decrementing.
- R4: The wrap flag (status bit 16) is set when the count steps from 1 to 0. A read of the control/status word returns the flag and then clears it.
- R5: `irq` is high only while the wrap flag is set and interrupt enable (bit 1) is 1. With bit 1 clear, a wrap still sets the flag but `irq` stays low.
- R6: A write of any value to the live-count register sets the count to 0 and never sets the wrap flag. This holds even when the count would have stepped from 1 to 0 on that same clock.
- R7: With count enable (bit 0) clear, the live count holds its value.
- R8: With a reload of 0 and counting enabled, the count stays at 0 and no wrap is ever flagged.
- R9: Control bit 2 (clock-source select) reads back the value last written to it.
- R10: If a wrap happens on the same clock as a control/status read, the read returns the old flag and the flag stays set afterwards.
- R11: While counting with a nonzero count, each clock lowers the live count by exactly one, so the elapsed ticks (reload minus count) rise by one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, also the counting clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register word offset: 0 control/status, 1 reload, 2 live count |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the strobe |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest cases to reach from the ports are the two races on the clock edge where the count steps from 1 to 0: one with a write that clears the count, one with a status read that clears the flag. The stimulus reaches that edge with back-to-back reads of the live count. Each read takes exactly one cycle, so the value it returns falls by one each time. Once a read returns 2, the next access lands on the clock edge where the count is 1. A write there must leave no flag and no interrupt. A status read there must return 0 and leave the flag set for the following read.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] OFS_CTRL    = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_RELOAD  = 2'd1;
  localparam logic [ADDR_W-1:0] OFS_CURRENT = 2'd2;

  localparam int unsigned BIT_RUN  = 0;
  localparam int unsigned BIT_IEN  = 1;
  localparam int unsigned BIT_SRC  = 2;
  localparam int unsigned BIT_WRAP = 16;

  typedef struct packed {
    logic src;
    logic ien;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/tick_ctrl_regs.sv
module tick_ctrl_regs
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_reload,
  input  logic              rd_ctrl,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wrap_evt,
  output ctrl_t             ctrl,
  output logic              wrap_flag,
  output logic [CNT_W-1:0]  reload_val
);
  ctrl_t            ctrl_q, ctrl_d;
  logic             flag_q, flag_d;
  logic [CNT_W-1:0] reload_q, reload_d;

  always_comb begin
    ctrl_d   = ctrl_q;
    reload_d = reload_q;
    flag_d   = flag_q;
    if (wr_ctrl) begin
      ctrl_d.run = wdata[BIT_RUN];
      ctrl_d.ien = wdata[BIT_IEN];
      ctrl_d.src = wdata[BIT_SRC];
    end
    if (wr_reload) reload_d = wdata[CNT_W-1:0];
    if (rd_ctrl)  flag_d = 1'b0;
    if (wrap_evt) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      flag_q   <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      reload_q <= reload_d;
      flag_q   <= flag_d;
    end
  end

  assign ctrl       = ctrl_q;
  assign wrap_flag  = flag_q;
  assign reload_val = reload_q;

  AST_FLAG_NEEDS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(wrap_evt)); // R4
  AST_WRAP_BEATS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> flag_q); // R10
endmodule

// File: rtl/tick_down_counter.sv
module tick_down_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             clr,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             wrap_evt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step;

  assign step = cnt_en && !clr;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                cnt_d = '0;
    else if (cnt_en) begin
      if (cnt_q == '0)      cnt_d = reload;
      else                  cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count    = cnt_q;
  assign wrap_evt = step && (cnt_q == ONE);

  AST_CLEAR_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0)); // R6
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !clr) |=> $stable(cnt_q)); // R7
  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE)); // R11
  AST_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q == '0) |=> (cnt_q == $past(reload))); // R3
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  logic wr_ctrl, wr_reload, wr_current, rd_ctrl;
  assign wr_ctrl    = bus_sel &&  bus_wr && (bus_addr == OFS_CTRL);
  assign wr_reload  = bus_sel &&  bus_wr && (bus_addr == OFS_RELOAD);
  assign wr_current = bus_sel &&  bus_wr && (bus_addr == OFS_CURRENT);
  assign rd_ctrl    = bus_sel && !bus_wr && (bus_addr == OFS_CTRL);

  ctrl_t            ctrl;
  logic             wrap_flag, wrap_evt;
  logic [CNT_W-1:0] reload_val, count;

  tick_ctrl_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .wr_ctrl(wr_ctrl), .wr_reload(wr_reload), .rd_ctrl(rd_ctrl),
    .wdata(bus_wdata), .wrap_evt(wrap_evt),
    .ctrl(ctrl), .wrap_flag(wrap_flag), .reload_val(reload_val)
  );

  tick_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n),
    .cnt_en(ctrl.run), .clr(wr_current), .reload(reload_val),
    .count(count), .wrap_evt(wrap_evt)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_CTRL: begin
        bus_rdata[BIT_RUN]  = ctrl.run;
        bus_rdata[BIT_IEN]  = ctrl.ien;
        bus_rdata[BIT_SRC]  = ctrl.src;
        bus_rdata[BIT_WRAP] = wrap_flag;
      end
      OFS_RELOAD:  bus_rdata[CNT_W-1:0] = reload_val;
      OFS_CURRENT: bus_rdata[CNT_W-1:0] = count;
      default:     bus_rdata = '0;
    endcase
  end

  assign irq = wrap_flag && ctrl.ien;

  AST_CLEAR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_current |=> !$rose(wrap_flag)); // R6
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq |-> bus_rdata[BIT_WRAP] || (bus_addr != OFS_CTRL)); // R5
endmodule

// File: tb/tick_timer_test.sv
`timescale 1ns/1ps
module tick_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  tick_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic stop_and_clear();
    logic [31:0] d;
    wr(2'd0, 32'h0);
    wr(2'd2, 32'h0);
    rd(2'd0, d);
  endtask

  task automatic poll_until(input int target);
    logic [31:0] d;
    for (int i = 0; i < 400; i++) begin
      rd(2'd2, d);
      if (d == target) return;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd0, d); check("R1 ctrl", d, 0);
    rd(2'd1, d); check("R1 reload", d, 0);
    rd(2'd2, d); check("R1 current", d, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_width();
    logic [31:0] d;
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); check("R2 reload truncation", d, 32'h00FF_FFFF);
    wr(2'd0, 32'h4);
    rd(2'd0, d); check("R9 source bit set", d, 32'h4);
    wr(2'd0, 32'h0);
    rd(2'd0, d); check("R9 source bit clear", d, 0);
  endtask

  task automatic t_period(input int n);
    logic [31:0] d;
    int cnt;
    wr(2'd1, n);
    wr(2'd0, 32'h3);
    for (int i = 0; i < 100 && !irq; i++) @(negedge clk);
    check("R5 irq raised", irq, 1);
    rd(2'd0, d);
    check("R4 flag read", d[16], 1);
    cnt = 1;
    for (int i = 0; i < 200 && !irq; i++) begin
      @(negedge clk);
      cnt++;
    end
    check("R3 period", cnt, n + 1);
    stop_and_clear();
    rd(2'd0, d); check("R4 flag cleared by read", d[16], 0);
    check("R4 irq low after clear", irq, 0);
  endtask

  task automatic t_no_irq();
    logic [31:0] d;
    wr(2'd1, 3);
    wr(2'd0, 32'h1);
    idle(20);
    check("R5 irq masked", irq, 0);
    rd(2'd0, d); check("R5 flag still set", d[16], 1);
    stop_and_clear();
  endtask

  task automatic t_decrement();
    logic [31:0] a, b;
    wr(2'd1, 1000);
    wr(2'd0, 32'h1);
    idle(5);
    rd(2'd2, a);
    rd(2'd2, b);
    check("R11 one tick per clock", 1000 - b, 1000 - a + 1);
    wr(2'd0, 32'h0);
    rd(2'd2, a);
    idle(7);
    rd(2'd2, b);
    check("R7 hold when disabled", b, a);
    stop_and_clear();
  endtask

  task automatic t_clear_race();
    logic [31:0] d;
    wr(2'd1, 50);
    wr(2'd0, 32'h3);
    poll_until(10);
    rd(2'd0, d);
    poll_until(2);
    wr(2'd2, 32'h1234);
    rd(2'd2, d); check("R6 current zero after write", d, 0);
    check("R6 no irq on clear", irq, 0);
    rd(2'd0, d); check("R6 no flag on clear", d[16], 0);
    stop_and_clear();
  endtask

  task automatic t_read_race();
    logic [31:0] d;
    wr(2'd1, 50);
    wr(2'd0, 32'h1);
    poll_until(10);
    rd(2'd0, d);
    poll_until(2);
    rd(2'd0, d); check("R10 read returns old flag", d[16], 0);
    rd(2'd0, d); check("R10 flag survives read", d[16], 1);
    stop_and_clear();
  endtask

  task automatic t_zero_reload();
    logic [31:0] d;
    wr(2'd1, 0);
    wr(2'd0, 32'h3);
    idle(30);
    check("R8 no irq", irq, 0);
    rd(2'd2, d); check("R8 count stays zero", d, 0);
    rd(2'd0, d); check("R8 no flag", d[16], 0);
    stop_and_clear();
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_width();
    t_period(4);
    t_period(9);
    t_no_irq();
    t_decrement();
    t_clear_race();
    t_read_race();
    t_zero_reload();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule